// File: doc/BRIEF.md
# Regulator Protection Fault Supervisor

This block manages protection faults in the digital part of a single-phase buck regulator controller. Analog comparators outside the block already turn output current and output voltage into one-bit flags: current above the trip level, a hard short, output under the soft-start reference by the undervoltage margin, output over it by the overvoltage margin, and severe overvoltage. The supervisor filters each flag in time according to its class. When a flag qualifies, the supervisor latches a fault, removes power-good, turns off both gate-driver enables and records which fault came first.

The filters need no external timing source. The block divides the system clock into microsecond ticks, and the parameter `CLK_PER_US` sets the divide ratio. A current-limit flag that lingers is integrated by an up/down counter that is sampled every `OC_SAMPLE_US` microseconds. A voltage excursion must stay present for more than `PERSIST_US` microseconds before it trips. Hard shorts and severe overvoltage are not filtered. Once a fault is latched it holds until the enable input drops or the supply power-on-reset indication drops.

Top module: `vr_fault_supervisor`

## Requirements
- R1: After reset, `fault_o` is 0 and `fault_cause_o` is 0. `pgood_o`, `hs_en_o` and `ls_en_o` are 1 only while `enable_i` and `por_ok_i` are both 1 and no fault is latched.
- R2: A severe-overvoltage flag presented while running is latched on the third rising clock edge after it is presented (two synchronizer stages, then the latch). Cause bit 4 is set.
- R3: A hard-short flag latches a fault within 2 us with no counting. Cause bit 3 is set.
- R4: The current-limit flag is sampled once every `OC_SAMPLE_US` (15) us, and each sample with the flag high adds one to a counter. The fault latches when the counter reaches `OC_TRIP_COUNT` (8). A flag held for 100 us does not trip, and one held for 125 us does. Cause bit 2 is set.
- R5: A sample with the current-limit flag low subtracts one from the counter. The counter saturates at zero, so a long low period does not delay a later trip.
- R6: An undervoltage flag held continuously for more than `PERSIST_US` (1000) us latches a fault, and one held for 990 us does not. Cause bit 0 is set.
- R7: An overvoltage flag held continuously for more than `PERSIST_US` us latches a fault, with cause bit 1 set. Any gap in the flag restarts its timer.
- R8: While a fault is latched, `pgood_o`, `hs_en_o` and `ls_en_o` are 0. The fault remains after every flag clears.
- R9: Taking `enable_i` low or `por_ok_i` low clears the fault and sets `fault_cause_o` to 0.
- R10: While `enable_i` or `por_ok_i` is low, every fault flag is ignored and no fault latches.
- R11: `fault_cause_o` is one-hot or zero. It keeps the first fault that latched, and faults that qualify later do not change it.
- R12: When faults qualify in the same cycle, the cause records only the one with the highest priority. The order is severe-OV (bit 4), hard short (bit 3), counted overcurrent (bit 2), OV (bit 1), UV (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Regulator enable; low releases a latched fault |
| por_ok_i | input | 1 | Supply above its power-on-reset threshold; low releases a latched fault |
| oc_over_i | input | 1 | Current above the overcurrent threshold |
| oc_short_i | input | 1 | Current above the hard-short level |
| uv_i | input | 1 | Output below the soft-start reference by the UV margin |
| ov_i | input | 1 | Output above the soft-start reference by the OV margin |
| sov_i | input | 1 | Output above the severe-overvoltage level |
| pgood_o | output | 1 | Power-good |
| hs_en_o | output | 1 | High-side gate driver enable |
| ls_en_o | output | 1 | Low-side gate driver enable |
| fault_o | output | 1 | A fault is latched |
| fault_cause_o | output | 5 | One-hot cause of the first latched fault |

## Verification
Two fault paths can qualify on the same clock edge, and the cause register then has to pick one of them. The bench forces this in two ways. It raises severe-overvoltage and hard-short together on one clock edge, and both are unfiltered. It also raises OV and UV together, so their persistence timers run out on the same tick. The bench then expects only the higher-priority cause bit in the one-hot cause, which is severe-OV in the first case and OV in the second. The bench also checks that a fault arriving after the latch leaves the cause unchanged, and that the counter's decrement and its zero floor change when the overcurrent trip fires.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;

  localparam int CAUSE_W   = 5;
  localparam int IDX_UV    = 0;
  localparam int IDX_OV    = 1;
  localparam int IDX_OC    = 2;
  localparam int IDX_SHORT = 3;
  localparam int IDX_SOV   = 4;

  typedef logic [CAUSE_W-1:0] cause_t;

  // Keep only the highest-index request; index order equals priority.
  function automatic cause_t pick_first(input cause_t req);
    cause_t res;
    res = '0;
    for (int i = 0; i < CAUSE_W; i++) begin
      if (req[i]) res = cause_t'(1) << i;
    end
    return res;
  endfunction

endpackage

// File: rtl/vrfs_sync.sv
module vrfs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end

    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/vrfs_tick.sv
module vrfs_tick #(
  parameter int CLK_PER_US = 100,
  parameter int SAMPLE_US  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic us_tick_o,
  output logic sample_o
);

  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int SMP_W = (SAMPLE_US > 1) ? $clog2(SAMPLE_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_US - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic             us_tick;

  always_comb begin
    div_d   = div_q;
    us_tick = 1'b0;
    if (clr) begin
      div_d = '0;
    end else if (div_q == DIV_LAST) begin
      div_d   = '0;
      us_tick = 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_comb begin
    smp_d = smp_q;
    if (clr) begin
      smp_d = '0;
    end else if (us_tick) begin
      if (smp_q == SMP_LAST) smp_d = '0;
      else                   smp_d = smp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      smp_q <= '0;
    end else begin
      div_q <= div_d;
      smp_q <= smp_d;
    end
  end

  assign us_tick_o = us_tick;
  assign sample_o  = us_tick && (smp_q == SMP_LAST);

endmodule

// File: rtl/vrfs_oc_integ.sv
module vrfs_oc_integ #(
  parameter int TRIP  = 8,
  parameter int CNT_W = $clog2(TRIP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic             over,
  output logic             trip_o,
  output logic [CNT_W-1:0] level_o
);

  localparam logic [CNT_W-1:0] TOP  = CNT_W'(TRIP);
  localparam logic [CNT_W-1:0] EDGE = CNT_W'(TRIP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (sample) begin
      if (over) begin
        if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trip_o  = !clr && sample && over && (cnt_q == EDGE);
  assign level_o = cnt_q;

endmodule

// File: rtl/vrfs_persist.sv
module vrfs_persist #(
  parameter int LIMIT_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic cond,
  output logic trip_o
);

  localparam int CNT_W = $clog2(LIMIT_US + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LIMIT_US);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !cond)                  cnt_d = '0;
    else if (tick && (cnt_q != LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Trips on the tick after LIMIT full microseconds: strictly longer than the window.
  assign trip_o = !clr && cond && tick && (cnt_q == LIMIT);

endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vrfs_pkg::*;
#(
  parameter int CLK_PER_US    = 100,
  parameter int OC_SAMPLE_US  = 15,
  parameter int OC_TRIP_COUNT = 8,
  parameter int PERSIST_US    = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               por_ok_i,
  input  logic               oc_over_i,
  input  logic               oc_short_i,
  input  logic               uv_i,
  input  logic               ov_i,
  input  logic               sov_i,
  output logic               pgood_o,
  output logic               hs_en_o,
  output logic               ls_en_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o
);

  localparam int OC_CNT_W = $clog2(OC_TRIP_COUNT + 1);
  localparam int IN_W     = 7;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IN_W-1:0] raw_in, syn_in;
  assign raw_in = {sov_i, oc_short_i, oc_over_i, ov_i, uv_i, por_ok_i, enable_i};

  vrfs_sync #(.WIDTH(IN_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  logic en_s, por_s, uv_s, ov_s, oc_s, short_s, sov_s;
  assign {sov_s, short_s, oc_s, ov_s, uv_s, por_s, en_s} = syn_in;

  logic run;
  logic latched_q, latched_d;
  cause_t cause_q, cause_d;
  logic filt_clr;

  assign run      = en_s && por_s;
  assign filt_clr = !run || latched_q;

  logic us_tick, oc_sample;
  vrfs_tick #(.CLK_PER_US(CLK_PER_US), .SAMPLE_US(OC_SAMPLE_US)) u_tick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (filt_clr),
    .us_tick_o (us_tick),
    .sample_o  (oc_sample)
  );

  logic                oc_trip;
  logic [OC_CNT_W-1:0] oc_level;
  vrfs_oc_integ #(.TRIP(OC_TRIP_COUNT), .CNT_W(OC_CNT_W)) u_oc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (filt_clr),
    .sample  (oc_sample),
    .over    (oc_s),
    .trip_o  (oc_trip),
    .level_o (oc_level)
  );

  logic [1:0] volt_cond, volt_trip;
  assign volt_cond = {ov_s, uv_s};

  for (genvar v = 0; v < 2; v++) begin : g_volt
    vrfs_persist #(.LIMIT_US(PERSIST_US)) u_persist (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr    (filt_clr),
      .tick   (us_tick),
      .cond   (volt_cond[v]),
      .trip_o (volt_trip[v])
    );
  end

  cause_t trips;
  always_comb begin
    trips            = '0;
    trips[IDX_UV]    = volt_trip[0];
    trips[IDX_OV]    = volt_trip[1];
    trips[IDX_OC]    = oc_trip;
    trips[IDX_SHORT] = short_s;
    trips[IDX_SOV]   = sov_s;
  end

  always_comb begin
    latched_d = latched_q;
    cause_d   = cause_q;
    if (!run) begin
      latched_d = 1'b0;
      cause_d   = '0;
    end else if (!latched_q && (trips != '0)) begin
      latched_d = 1'b1;
      cause_d   = pick_first(trips);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      latched_q <= 1'b0;
      cause_q   <= '0;
    end else begin
      latched_q <= latched_d;
      cause_q   <= cause_d;
    end
  end

  assign fault_o       = latched_q;
  assign fault_cause_o = cause_q;
  assign pgood_o       = run && !latched_q;
  assign hs_en_o       = run && !latched_q;
  assign ls_en_o       = run && !latched_q;

endmodule

// File: rtl/vrfs_checker.sv
module vrfs_checker #(
  parameter int CNT_W = 4,
  parameter int TRIP  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sov,
  input logic [CNT_W-1:0] oc_level,
  input logic             pgood,
  input logic             hs_en,
  input logic             ls_en,
  input logic             fault,
  input logic [4:0]       cause
);

  assert_gates_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!pgood && !hs_en && !ls_en));

  assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause) && (fault == (cause != 5'd0)));

  assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && run) |=> (fault && $stable(cause)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!fault && cause == 5'd0));

  assert_sov_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fault && sov) |=> (fault && cause[4]));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_level <= CNT_W'(TRIP));

endmodule

bind vr_fault_supervisor vrfs_checker #(.CNT_W(OC_CNT_W), .TRIP(OC_TRIP_COUNT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (run),
  .sov      (sov_s),
  .oc_level (oc_level),
  .pgood    (pgood_o),
  .hs_en    (hs_en_o),
  .ls_en    (ls_en_o),
  .fault    (fault_o),
  .cause    (fault_cause_o)
);

// File: tb/vr_fault_supervisor_test.sv
`timescale 1ns/1ps
module vr_fault_supervisor_test;

  localparam int CPU = 4;

  logic clk;
  logic rst_n;
  logic enable_i, por_ok_i, oc_over_i, oc_short_i, uv_i, ov_i, sov_i;
  logic pgood_o, hs_en_o, ls_en_o, fault_o;
  logic [4:0] fault_cause_o;

  int tests  = 0;
  int failed = 0;
  int cycles = 0;
  bit done   = 0;

  vr_fault_supervisor #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .por_ok_i(por_ok_i),
    .oc_over_i(oc_over_i), .oc_short_i(oc_short_i), .uv_i(uv_i), .ov_i(ov_i),
    .sov_i(sov_i), .pgood_o(pgood_o), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o),
    .fault_o(fault_o), .fault_cause_o(fault_cause_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      failed++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_us(input int n);
    cyc(n * CPU);
  endtask

  task automatic flags_low();
    oc_over_i = 0; oc_short_i = 0; uv_i = 0; ov_i = 0; sov_i = 0;
  endtask

  task automatic restart();
    flags_low();
    enable_i = 0;
    cyc(4);
    enable_i = 1;
    por_ok_i = 1;
    cyc(4);
  endtask

  task automatic t_reset();
    check("R1 fault after reset", fault_o, 0);
    check("R1 cause after reset", fault_cause_o, 0);
    check("R1 pgood while disabled", pgood_o, 0);
    enable_i = 1; por_ok_i = 1;
    cyc(4);
    check("R1 pgood running", pgood_o, 1);
    check("R1 gate enables running", {hs_en_o, ls_en_o}, 2'b11);
  endtask

  task automatic t_sov();
    restart();
    sov_i = 1;
    cyc(2);
    check("R2 not yet latched after two edges", fault_o, 0);
    cyc(1);
    check("R2 latched on third edge", fault_o, 1);
    check("R2 cause severe-OV", fault_cause_o, 5'b10000);
    check("R8 outputs off", {pgood_o, hs_en_o, ls_en_o}, 3'b000);
    sov_i = 0;
    wait_us(5);
    check("R8 fault held after flag clears", fault_o, 1);
    enable_i = 0;
    cyc(4);
    check("R9 enable low clears fault", {fault_o, fault_cause_o}, 6'd0);
  endtask

  task automatic t_short();
    restart();
    oc_short_i = 1;
    wait_us(2);
    check("R3 hard short within 2us", fault_o, 1);
    check("R3 cause hard short", fault_cause_o, 5'b01000);
  endtask

  task automatic t_oc_trip();
    restart();
    oc_over_i = 1;
    wait_us(100);
    check("R4 no trip at 100us", fault_o, 0);
    wait_us(25);
    check("R4 trip by 125us", fault_o, 1);
    check("R4 cause counted OC", fault_cause_o, 5'b00100);
  endtask

  task automatic t_oc_decay();
    restart();
    oc_over_i = 1; wait_us(90);
    oc_over_i = 0; wait_us(90);
    oc_over_i = 1; wait_us(60);
    check("R5 decrement keeps count below trip", fault_o, 0);
    wait_us(150);
    check("R5 trip after sustained OC", fault_o, 1);
    restart();
    wait_us(300);
    oc_over_i = 1;
    wait_us(125);
    check("R5 zero floor then trip in 125us", fault_o, 1);
  endtask

  task automatic t_uv();
    restart();
    uv_i = 1;
    wait_us(990);
    check("R6 no UV trip at 990us", fault_o, 0);
    wait_us(15);
    check("R6 UV trip after window", fault_o, 1);
    check("R6 cause UV", fault_cause_o, 5'b00001);
  endtask

  task automatic t_ov_first();
    restart();
    ov_i = 1; wait_us(600);
    ov_i = 0; wait_us(5);
    ov_i = 1; wait_us(600);
    check("R7 gap restarts OV timer", fault_o, 0);
    wait_us(450);
    check("R7 OV trip", fault_o, 1);
    check("R7 cause OV", fault_cause_o, 5'b00010);
    sov_i = 1;
    wait_us(2);
    check("R11 later fault keeps first cause", fault_cause_o, 5'b00010);
  endtask

  task automatic t_ignored();
    restart();
    enable_i = 0;
    sov_i = 1; oc_short_i = 1;
    wait_us(5);
    check("R10 flags ignored while disabled", {fault_o, fault_cause_o}, 6'd0);
    flags_low();
    cyc(4);
    enable_i = 1; por_ok_i = 0;
    sov_i = 1;
    wait_us(5);
    check("R10 flags ignored while POR low", {fault_o, fault_cause_o}, 6'd0);
    sov_i = 0;
    cyc(4);
    por_ok_i = 1;
    cyc(4);
    check("R10 clean start after POR", {fault_o, pgood_o}, 2'b01);
  endtask

  task automatic t_por_clear();
    restart();
    sov_i = 1;
    cyc(4);
    sov_i = 0;
    check("R9 latched before POR drop", fault_o, 1);
    por_ok_i = 0;
    wait_us(1);
    check("R9 POR low clears fault", {fault_o, fault_cause_o}, 6'd0);
    por_ok_i = 1;
    cyc(4);
    check("R9 pgood back after POR", pgood_o, 1);
  endtask

  task automatic t_prio();
    restart();
    sov_i = 1; oc_short_i = 1;
    cyc(4);
    check("R12 severe-OV beats hard short", fault_cause_o, 5'b10000);
    restart();
    ov_i = 1; uv_i = 1;
    wait_us(1005);
    check("R12 OV beats UV on same tick", fault_cause_o, 5'b00010);
  endtask

  initial begin
    rst_n = 0;
    enable_i = 0; por_ok_i = 0;
    flags_low();
    cyc(3);
    rst_n = 1;
    cyc(4);
    t_reset();
    t_sov();
    t_short();
    t_oc_trip();
    t_oc_decay();
    t_uv();
    t_ov_first();
    t_ignored();
    t_por_clear();
    t_prio();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule